// File: doc/BRIEF.md
# Zoned Bandwidth Monitor Core

This block measures the traffic on one monitored bus port. It adds up the bytes reported on a beat input over a sampling window, which is counted in timer ticks. At the end of each window it scales the total into count units of 64 bytes. It then places the window in one of four bandwidth zones by comparing it against three programmable thresholds.

Each zone has a hit counter. A zone hit applies that zone's programmed action byte: the byte can increment or clear the hit counter of any zone. When an incremented counter reaches the zone's repeat count, the zone's interrupt status bit is set. The block also keeps the largest window count seen in each zone.

Software programs the block through a word-addressed 32-bit register port and services the level interrupt. Between interrupts it retunes the thresholds.

Top module: `bw_zone_mon`

## Requirements
- R1: A window is classified by priority. It is zone 3 if its count is greater than HIGH, else zone 2 if greater than MED, else zone 1 if greater than LOW, else zone 0. A count equal to a threshold falls in the lower zone.
- R2: The window count is the accumulated byte total shifted right by 6, and it saturates at 4095 instead of wrapping.
- R3: With a window length of N, a window ends on the Nth cycle in which tick_en is high since the last window end.
- R4: A beat presented in the same cycle as a window end is counted in the next window, not the closing one. No bytes are lost.
- R5: Action byte z sits at bits 8z+7:8z of the actions register. When zone z is hit, bit 2t+1 of that byte increments zone t's hit counter and bit 2t clears it. A clear wins over an increment. Hit counters saturate at 255.
- R6: On a hit of zone z whose count exceeds the stored maximum of zone z, the maximum takes that count. Otherwise it is kept.
- R7: The status bit of zone t is set when a window increments zone t's hit counter to a value at or above repeat byte t (bits 8t+7:8t). A repeat value of 255 never sets status.
- R8: Status bits are sticky until a one is written to the matching bit of the zone clear register. Only status bits whose zone enable bit is set can raise the interrupt.
- R9: Any pending enabled zone sets a global flag, and irq is that flag gated by the global enable bit. Writing the global clear drops irq for one cycle. The flag is set again on the next cycle while an enabled zone stays pending.
- R10: With bit 0 of the control register low, no windows end, beats and ticks are discarded, and hit counters and maxima stay unchanged.
- R11: Writing the clear register with bit 0 set restarts the byte total and tick count. Writing it with bit 1 set also zeroes all hit counters and maxima.
- R12: Word addresses are as follows:
  - 0: control
  - 1: clear
  - 2: window length
  - 3: LOW
  - 4: MED
  - 5: HIGH
  - 6: actions
  - 7: repeat
  - 8: status
  - 9: zone clear
  - 10: zone enable
  - 11: global enable
  - 12: global clear
  - 16+z: maximum of zone z
  - 20+z: hit counter of zone z

  The clear registers (1, 9, 12) read as zero. Everything resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| tick_en | input | 1 | Sampling timer tick |
| beat_valid | input | 1 | Beat carries a byte count |
| beat_bytes | input | 16 | Bytes moved by this beat |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are the timing corners: a beat landing on the very cycle that closes a window, and the one-cycle gap of irq after a global clear while a zone is still pending. The bench drives tick_en as a single-cycle pulse, and can raise it together with a beat. This places the boundary exactly and lets the closing window be seen as empty. Hit-counter saturation with a muted repeat value is reached by a loop of several hundred short windows. Saturation of the count itself is reached with a few beats that together exceed the 18-bit byte range.

// File: rtl/bzm_pkg.sv
// Shared constants and types for the zoned bandwidth monitor.
// Assumes a fixed four-zone organisation with 8-bit action/repeat bytes.
package bzm_pkg;
    localparam int NZ    = 4;
    localparam int ZW    = 2;
    localparam int HIT_W = 8;
    localparam int ACT_W = 2 * NZ;
    typedef logic [ZW-1:0] zone_t;
endpackage

// File: rtl/bzm_window.sv
// Sampling window engine: counts ticks up to the programmed length and
// accumulates beat bytes with saturation. Assumes BEAT_W <= CNT_W+UNIT_SHIFT.
module bzm_window #(
    parameter int WIN_W      = 24,
    parameter int BEAT_W     = 16,
    parameter int CNT_W      = 12,
    parameter int UNIT_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_en,
    input  logic              clr_run,
    input  logic              tick_en,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              win_end,
    output logic [CNT_W-1:0]  win_count
);
    localparam int ACC_W = CNT_W + UNIT_SHIFT;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic [ACC_W-1:0] acc;
    logic [WIN_W-1:0] tick_cnt;
    logic [ACC_W:0]   beat_ext;
    logic [ACC_W:0]   acc_sum;
    logic             last_tick;

    // Beat size, byte sum and window-end detection.
    always_comb begin
        beat_ext  = beat_valid ? (ACC_W+1)'(beat_bytes) : '0;
        acc_sum   = {1'b0, acc} + beat_ext;
        last_tick = ({1'b0, tick_cnt} + 1'b1) >= {1'b0, win_len};
        win_end   = mon_en && !clr_run && tick_en && last_tick;
        win_count = acc[ACC_W-1:UNIT_SHIFT];
    end

    // Tick counter and saturating byte accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || !mon_en || clr_run) begin
            acc      <= '0;
            tick_cnt <= '0;
        end else if (win_end) begin
            tick_cnt <= '0;
            acc      <= beat_ext[ACC_W-1:0];
        end else begin
            acc      <= acc_sum[ACC_W] ? ACC_MAX : acc_sum[ACC_W-1:0];
            if (tick_en) tick_cnt <= tick_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bzm_classify.sv
// Zone classifier: priority compare of a window count against three
// thresholds, strict greater-than. Assumes LOW <= MED <= HIGH for sense.
module bzm_classify
    import bzm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thr_low,
    input  logic [CNT_W-1:0] thr_med,
    input  logic [CNT_W-1:0] thr_high,
    output zone_t            zone
);
    // Highest threshold exceeded selects the zone.
    always_comb begin
        if (count > thr_high)     zone = 2'd3;
        else if (count > thr_med) zone = 2'd2;
        else if (count > thr_low) zone = 2'd1;
        else                      zone = 2'd0;
    end
endmodule

// File: rtl/bzm_zone_bank.sv
// Per-zone hit counters, maxima and status-set pulses. Applies the hit
// zone's action byte to every target zone at a window end.
module bzm_zone_bank
    import bzm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_all,
    input  logic                  win_end,
    input  zone_t                 zone,
    input  logic [CNT_W-1:0]      count,
    input  logic [NZ*ACT_W-1:0]   actions,
    input  logic [NZ*HIT_W-1:0]   repeats,
    output logic [NZ*HIT_W-1:0]   hits,
    output logic [NZ*CNT_W-1:0]   zmax,
    output logic [NZ-1:0]         set_stat
);
    localparam logic [HIT_W-1:0] HIT_MAX = '1;

    logic [ACT_W-1:0] act;

    // Action byte of the zone that was hit.
    always_comb act = actions[zone*ACT_W +: ACT_W];

    for (genvar t = 0; t < NZ; t++) begin : g_zone
        logic             inc, clr;
        logic [HIT_W-1:0] hit_q, hit_inc, rep;
        logic [CNT_W-1:0] max_q;

        // Decode this zone's action bits and its next incremented value.
        always_comb begin
            inc         = act[2*t+1];
            clr         = act[2*t];
            rep         = repeats[t*HIT_W +: HIT_W];
            hit_inc     = (hit_q == HIT_MAX) ? HIT_MAX : hit_q + 1'b1;
            set_stat[t] = win_end && inc && !clr && (hit_inc >= rep) && (rep != HIT_MAX);
        end

        // Hit counter update.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)      hit_q <= '0;
            else if (win_end && clr)    hit_q <= '0;
            else if (win_end && inc)    hit_q <= hit_inc;
        end

        // Largest count seen in this zone.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)                                max_q <= '0;
            else if (win_end && zone == ZW'(t) && count > max_q)  max_q <= count;
        end

        assign hits[t*HIT_W +: HIT_W] = hit_q;
        assign zmax[t*CNT_W +: CNT_W] = max_q;
    end
endmodule

// File: rtl/bw_zone_mon.sv
// Zoned bandwidth monitor top: register file, interrupt status and the
// global interrupt flag. Register port reads are combinational.
module bw_zone_mon
    import bzm_pkg::*;
#(
    parameter int WIN_W      = 24,
    parameter int BEAT_W     = 16,
    parameter int CNT_W      = 12,
    parameter int UNIT_SHIFT = 6,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tick_en,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = 0, A_CLR = 1, A_WIN = 2, A_LOW = 3,
        A_MED = 4, A_HIGH = 5, A_ACT = 6, A_REP = 7, A_STAT = 8, A_ZCLR = 9,
        A_ZEN = 10, A_GEN = 11, A_GCLR = 12, A_MAX = 16, A_HIT = 20;

    logic                mon_en, gen_en, gbl_flag;
    logic [WIN_W-1:0]    win_len;
    logic [CNT_W-1:0]    thr_low, thr_med, thr_high, win_count;
    logic [NZ*ACT_W-1:0] actions;
    logic [NZ*HIT_W-1:0] repeats, hits;
    logic [NZ*CNT_W-1:0] zmax;
    logic [NZ-1:0]       stat, zen, set_stat;
    logic                clr_run, clr_all, zclr_wr, gclr_wr, win_end;
    zone_t               zone;

    // Write-only action strobes.
    always_comb begin
        clr_run = reg_we && reg_addr == A_CLR && (reg_wdata[0] || reg_wdata[1]);
        clr_all = reg_we && reg_addr == A_CLR && reg_wdata[1];
        zclr_wr = reg_we && reg_addr == A_ZCLR;
        gclr_wr = reg_we && reg_addr == A_GCLR && reg_wdata[0];
    end

    // Programmable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_en <= 1'b0; gen_en <= 1'b0; win_len <= '0; zen <= '0;
            thr_low <= '0; thr_med <= '0; thr_high <= '0;
            actions <= '0; repeats <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTRL: mon_en   <= reg_wdata[0];
                A_WIN:  win_len  <= reg_wdata[WIN_W-1:0];
                A_LOW:  thr_low  <= reg_wdata[CNT_W-1:0];
                A_MED:  thr_med  <= reg_wdata[CNT_W-1:0];
                A_HIGH: thr_high <= reg_wdata[CNT_W-1:0];
                A_ACT:  actions  <= reg_wdata[NZ*ACT_W-1:0];
                A_REP:  repeats  <= reg_wdata[NZ*HIT_W-1:0];
                A_ZEN:  zen      <= reg_wdata[NZ-1:0];
                A_GEN:  gen_en   <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    bzm_window #(.WIN_W(WIN_W), .BEAT_W(BEAT_W), .CNT_W(CNT_W), .UNIT_SHIFT(UNIT_SHIFT)) u_win (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .clr_run(clr_run), .tick_en(tick_en),
        .win_len(win_len), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
        .win_end(win_end), .win_count(win_count));

    bzm_classify #(.CNT_W(CNT_W)) u_cls (
        .count(win_count), .thr_low(thr_low), .thr_med(thr_med), .thr_high(thr_high),
        .zone(zone));

    bzm_zone_bank #(.CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .win_end(win_end), .zone(zone),
        .count(win_count), .actions(actions), .repeats(repeats), .hits(hits),
        .zmax(zmax), .set_stat(set_stat));

    // Sticky zone status; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~(zclr_wr ? reg_wdata[NZ-1:0] : '0)) | set_stat;
    end

    // Global flag: re-armed every cycle an enabled zone is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)              gbl_flag <= 1'b0;
        else if (gclr_wr)        gbl_flag <= 1'b0;
        else if (|(stat & zen))  gbl_flag <= 1'b1;
    end

    assign irq = gbl_flag && gen_en;

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata[0]            = mon_en;
            A_WIN:  reg_rdata[WIN_W-1:0]    = win_len;
            A_LOW:  reg_rdata[CNT_W-1:0]    = thr_low;
            A_MED:  reg_rdata[CNT_W-1:0]    = thr_med;
            A_HIGH: reg_rdata[CNT_W-1:0]    = thr_high;
            A_ACT:  reg_rdata               = 32'(actions);
            A_REP:  reg_rdata               = 32'(repeats);
            A_STAT: reg_rdata[NZ-1:0]       = stat;
            A_ZEN:  reg_rdata[NZ-1:0]       = zen;
            A_GEN:  reg_rdata[0]            = gen_en;
            default: begin
                if (reg_addr >= A_MAX && reg_addr < A_MAX + NZ)
                    reg_rdata[CNT_W-1:0] = zmax[(reg_addr - A_MAX)*CNT_W +: CNT_W];
                else if (reg_addr >= A_HIT && reg_addr < A_HIT + NZ)
                    reg_rdata[HIT_W-1:0] = hits[(reg_addr - A_HIT)*HIT_W +: HIT_W];
            end
        endcase
    end
endmodule

// File: rtl/bzm_chk.sv
// Checker for bw_zone_mon, attached by bind. Observes the interrupt path,
// status timing and the monotonic behaviour of maxima and hit counters.
module bzm_chk
    import bzm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq,
    input logic                gen_en,
    input logic                gclr_wr,
    input logic                win_end,
    input logic                mon_en,
    input logic                clr_all,
    input logic [NZ-1:0]       stat,
    input logic [NZ*HIT_W-1:0] hits,
    input logic [NZ*CNT_W-1:0] zmax
);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> gen_en);
    // R9
    gclr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) gclr_wr |=> !irq);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en && !clr_all) |=> $stable(hits) && $stable(zmax));

    for (genvar z = 0; z < NZ; z++) begin : g_chk
        // R7
        stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat[z]) |-> $past(win_end));
        // R6
        max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_all |=> zmax[z*CNT_W +: CNT_W] >= $past(zmax[z*CNT_W +: CNT_W]));
    end
endmodule

bind bw_zone_mon bzm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .gen_en(gen_en), .gclr_wr(gclr_wr),
    .win_end(win_end), .mon_en(mon_en), .clr_all(clr_all), .stat(stat),
    .hits(hits), .zmax(zmax));

// File: tb/sim_bw_zone_mon.sv
module sim_bw_zone_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_en = 1'b0;
    logic        beat_valid = 1'b0;
    logic [15:0] beat_bytes = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bw_zone_mon u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
        .beat_valid(beat_valid), .beat_bytes(beat_bytes), .irq(irq));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic beat(input int bytes);
        @(negedge clk);
        beat_valid = 1'b1; beat_bytes = 16'(bytes);
        @(negedge clk);
        beat_valid = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    // One window of the given count units, window length 1
    task automatic window(input int units);
        if (units > 0) beat(units * 64);
        tick();
    endtask

    task automatic t_reset();
        chk("R9 irq at reset", 32'(irq), 0);
        rd_chk("R12 status at reset", 5'd8, 0);
        rd_chk("R12 window at reset", 5'd2, 0);
        rd_chk("R12 hit3 at reset", 5'd23, 0);
    endtask

    task automatic t_setup();
        wr(5'd0, 1); wr(5'd2, 1);
        wr(5'd3, 2); wr(5'd4, 5); wr(5'd5, 9);
        wr(5'd6, 32'h9525_0901);
        wr(5'd7, 32'hFFFF_FFFF);
    endtask

    task automatic t_zones();
        window(7);
        rd_chk("R1 count 7 in zone2 hit2", 5'd22, 1);
        rd_chk("R6 max2 takes 7", 5'd18, 7);
        window(3);
        rd_chk("R1 count 3 in zone1 hit1", 5'd21, 1);
        window(10);
        rd_chk("R1 count 10 in zone3 hit3", 5'd23, 1);
        rd_chk("R5 zone3 clears hit2", 5'd22, 0);
        rd_chk("R5 zone3 clears hit1", 5'd21, 0);
        window(9);
        rd_chk("R1 count equal HIGH stays zone2", 5'd22, 1);
        rd_chk("R1 equal HIGH not zone3", 5'd23, 1);
        window(2);
        rd_chk("R1 count equal LOW is zone0", 5'd21, 0);
        rd_chk("R5 zone0 leaves hit2", 5'd22, 1);
        window(6);
        rd_chk("R6 max2 keeps larger 9", 5'd18, 9);
        rd_chk("R5 hit2 increments", 5'd22, 2);
    endtask

    task automatic t_window_len();
        wr(5'd2, 3);
        beat(640);
        tick(); tick();
        rd_chk("R3 no end before third tick", 5'd23, 1);
        tick();
        rd_chk("R3 window ends on third tick", 5'd23, 2);
        wr(5'd2, 1);
    endtask

    task automatic t_boundary();
        @(negedge clk);
        beat_valid = 1'b1; beat_bytes = 16'd640; tick_en = 1'b1;
        @(negedge clk);
        beat_valid = 1'b0; tick_en = 1'b0;
        rd_chk("R4 boundary beat not in closing window", 5'd23, 2);
        tick();
        rd_chk("R4 boundary beat counted in next window", 5'd23, 3);
    endtask

    task automatic t_sat();
        for (int i = 0; i < 5; i++) beat(60000);
        tick();
        rd_chk("R2 count saturates at 4095", 5'd19, 32'hFFF);
    endtask

    task automatic t_irq();
        wr(5'd1, 2);
        rd_chk("R11 clear all zeroes max3", 5'd19, 0);
        rd_chk("R11 clear all zeroes hit2", 5'd22, 0);
        wr(5'd7, 32'h02FF_FFFF);
        wr(5'd10, 8); wr(5'd11, 1);
        window(10);
        rd_chk("R7 below repeat no status", 5'd8, 0);
        window(10);
        rd_chk("R7 repeat reached sets status", 5'd8, 8);
        @(negedge clk);
        chk("R9 irq raised", 32'(irq), 1);
    endtask

    task automatic t_gclr();
        wr(5'd12, 1);
        chk("R9 irq drops after global clear", 32'(irq), 0);
        @(negedge clk);
        chk("R9 irq re-asserts while pending", 32'(irq), 1);
    endtask

    task automatic t_zclr();
        wr(5'd9, 8);
        rd_chk("R8 zone clear drops status", 5'd8, 0);
        wr(5'd12, 1);
        @(negedge clk); @(negedge clk);
        chk("R8 irq stays low after both clears", 32'(irq), 0);
    endtask

    task automatic t_mask();
        wr(5'd10, 0);
        window(10);
        rd_chk("R8 status set while masked", 5'd8, 8);
        @(negedge clk); @(negedge clk);
        chk("R8 masked zone gives no irq", 32'(irq), 0);
        wr(5'd10, 8);
        @(negedge clk); @(negedge clk);
        chk("R8 unmasking raises irq", 32'(irq), 1);
        wr(5'd11, 0);
        chk("R9 global enable off drops irq", 32'(irq), 0);
    endtask

    task automatic t_disable();
        wr(5'd0, 0);
        beat(640);
        tick();
        rd_chk("R10 no window while disabled", 5'd23, 3);
        wr(5'd0, 1);
        tick();
        rd_chk("R10 beat while disabled discarded", 5'd23, 3);
        rd_chk("R10 max0 untouched", 5'd16, 0);
    endtask

    task automatic t_clear_run();
        beat(640);
        wr(5'd1, 1);
        tick();
        rd_chk("R11 running clear drops bytes", 5'd23, 3);
        rd_chk("R11 running clear keeps max3", 5'd19, 10);
    endtask

    task automatic t_readzero();
        rd_chk("R12 clear reads zero", 5'd1, 0);
        rd_chk("R12 zone clear reads zero", 5'd9, 0);
        rd_chk("R12 global clear reads zero", 5'd12, 0);
    endtask

    task automatic t_mute();
        wr(5'd7, 32'hFFFF_FFFF);
        wr(5'd9, 32'hF);
        for (int i = 0; i < 260; i++) window(10);
        rd_chk("R5 hit counter saturates at 255", 5'd23, 255);
        rd_chk("R7 repeat 255 mutes zone", 5'd8, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_zones();
        t_window_len();
        t_boundary();
        t_sat();
        t_irq();
        t_gclr();
        t_zclr();
        t_mask();
        t_disable();
        t_clear_run();
        t_readzero();
        t_mute();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule